// File: doc/BRIEF.md
# Low-Voltage Reset Supervisor Controller

This block is the digital half of a supply supervisor. Three comparators report whether the supply is below the power-on level, below a high trip level and below a low trip level. The block turns those into a chip reset, a low-voltage interrupt flag and a signal that forbids the deepest stop mode. It also keeps a small status word that records what caused the most recent reset. The comparators are modelled as asynchronous digital inputs. Each one is synchronized. The two trip-level inputs must also hold steady for a programmable number of clocks before the block acts on them.

A set of control bits sits inside the block and takes its defaults on every power-on event. These bits enable the detector, choose between reset and interrupt on a trip, pick the high or low threshold, keep the detector running in stop mode, and enable the interrupt. When the supply falls below the selected level, the block either holds the chip in reset until the supply recovers past that same level, or it raises a sticky flag that software acknowledges. A power-on event always holds reset until the supply is above the low level. Other reset sources outside the block are only recorded in the status word.

Top module: `lvr_supervisor`

## Requirements
- R1: A trip-level input acts only after it has held a new value for FILT_CYC consecutive synchronized clocks. A pulse of two clocks or less causes neither a reset nor a flag.
- R2: A trip has effect only when control bit 0 (detector enable) is 1. While `in_stop_i` is 1, a trip also needs control bit 3 (stop keep-alive) to be 1.
- R3: `stop2_inhibit_o` is 1 one clock after control bits 0 and 3 are both 1, and 0 otherwise.
- R4: When `por_below_i` is 1, `chip_rst_o` is 1 within four clocks.
- R5: After a power-on event, `chip_rst_o` stays 1 until `por_below_i` is 0 and `below_lo_i` is 0. `below_hi_i` has no part in this.
- R6: A power-on event loads the status word with bit 0 (power-on cause) and bit 1 (low-voltage cause) set and every other bit clear.
- R7: With control bit 1 (reset enable) set, a trip of the level chosen by control bit 2 (1 = high, 0 = low) asserts `chip_rst_o`. Reset stays asserted until that same level is no longer tripped.
- R8: A low-voltage reset loads the status word with only bit 1 set.
- R9: With control bit 1 clear, a trip sets `lv_flag_o` and leaves `chip_rst_o` at 0. `lv_irq_o` equals `lv_flag_o` AND control bit 4 (interrupt enable).
- R10: `lv_flag_o` stays set after the trip ends, and a one-clock pulse on `flag_ack_i` clears it.
- R11: A pulse on `ext_rst_i[i]` loads the status word with only bit 2+i set. It does not assert `chip_rst_o`.
- R12: The control word (bit 0 detector enable, bit 1 reset enable, bit 2 high select, bit 3 stop keep-alive, bit 4 interrupt enable) is written through `cfg_we_i`/`cfg_wr_i` and read on `cfg_o`. It returns to 5'b00011 on `rst` and on each power-on event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high initialization, treated as a power-on event |
| por_below_i | input | 1 | Supply below power-on level (asynchronous) |
| below_hi_i | input | 1 | Supply below high trip level (asynchronous) |
| below_lo_i | input | 1 | Supply below low trip level (asynchronous) |
| in_stop_i | input | 1 | Chip is in a stop mode |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wr_i | input | 5 | Control word write data |
| flag_ack_i | input | 1 | Clear the low-voltage flag |
| ext_rst_i | input | N_EXT | One-clock pulses from other reset sources |
| chip_rst_o | output | 1 | Chip reset request |
| lv_flag_o | output | 1 | Low-voltage flag |
| lv_irq_o | output | 1 | Low-voltage interrupt request |
| stop2_inhibit_o | output | 1 | Deepest stop mode is forbidden |
| rst_status_o | output | N_EXT+2 | Causes of the latest reset |
| cfg_o | output | 5 | Control word readback |

## Verification
The assertions assume the comparator levels are ordered: the supply is never below the low level without also being below the high level. The bench therefore never drives `below_lo_i` high with `below_hi_i` low. The assertions also assume that `ext_rst_i` pulses and control writes do not land in the same clock as a power-on change. Every stimulus step in the bench is separated by several idle clocks, and comparator levels are held long enough to pass the filter, apart from the one deliberate short glitch.

// File: rtl/lvr_pkg.sv
package lvr_pkg;

    typedef struct packed {
        logic irq_en;   // bit 4
        logic stop_en;  // bit 3
        logic hi_sel;   // bit 2
        logic rst_en;   // bit 1
        logic det_en;   // bit 0
    } lvr_cfg_t;

    localparam lvr_cfg_t CFG_DEFAULT = '{irq_en: 1'b0, stop_en: 1'b0, hi_sel: 1'b0,
                                         rst_en: 1'b1, det_en: 1'b1};

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_HOLD_POR = 2'd1,
        ST_HOLD_LV  = 2'd2
    } lvr_state_t;

    // Trip of the threshold currently selected
    function automatic logic pick_trip(lvr_cfg_t c, logic below_hi, logic below_lo);
        return c.hi_sel ? below_hi : below_lo;
    endfunction

    // Detector alive given enable and stop gating
    function automatic logic det_live(lvr_cfg_t c, logic in_stop);
        return c.det_en && (!in_stop || c.stop_en);
    endfunction

endpackage

// File: rtl/lvr_cmp_cond.sv
module lvr_cmp_cond #(
    parameter int STAGES   = 2,
    parameter int FILT_CYC = 4,
    parameter bit USE_FILT = 1'b1,
    parameter bit RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic cond_o
);
    localparam int CNT_W = $clog2(FILT_CYC + 1);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], raw_i};
    end

    logic synced;
    assign synced = chain[STAGES-1];

    generate
        if (USE_FILT) begin : g_filt
            logic [CNT_W-1:0] cnt;
            logic             held;
            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt  <= '0;
                    held <= RST_VAL;
                end else if (synced != held) begin
                    if (cnt == CNT_W'(FILT_CYC - 1)) begin
                        held <= synced;
                        cnt  <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end else begin
                    cnt <= '0;
                end
            end
            assign cond_o = held;
        end else begin : g_direct
            assign cond_o = synced;
        end
    endgenerate
endmodule

// File: rtl/lvr_ctrl.sv
module lvr_ctrl
    import lvr_pkg::*;
#(
    parameter int N_EXT = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             por_s,
    input  logic             hi_f,
    input  logic             lo_f,
    input  logic             in_stop,
    input  logic             cfg_we,
    input  lvr_cfg_t         cfg_wr,
    input  logic             flag_ack,
    input  logic [N_EXT-1:0] ext_rst,
    output logic             chip_rst,
    output logic             lv_flag,
    output logic             lv_irq,
    output logic             stop2_inhibit,
    output logic [N_EXT+1:0] status,
    output lvr_cfg_t         cfg_q
);
    lvr_state_t state, nxt;
    logic trip, live, por_evt, lv_evt, flag_set;

    assign trip     = pick_trip(cfg_q, hi_f, lo_f);
    assign live     = det_live(cfg_q, in_stop);
    assign por_evt  = por_s && (state != ST_HOLD_POR);
    assign lv_evt   = !por_s && (state == ST_RUN) && live && trip && cfg_q.rst_en;
    assign flag_set = !por_s && (state == ST_RUN) && live && trip && !cfg_q.rst_en;

    always_comb begin
        nxt = state;
        if (por_s) begin
            nxt = ST_HOLD_POR;
        end else begin
            unique case (state)
                ST_RUN:      if (lv_evt) nxt = ST_HOLD_LV;
                ST_HOLD_POR: if (!lo_f)  nxt = ST_RUN;
                ST_HOLD_LV:  if (!trip)  nxt = ST_RUN;
                default:     nxt = ST_HOLD_POR;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_HOLD_POR;
            chip_rst      <= 1'b1;
            status        <= {{N_EXT{1'b0}}, 2'b11};
            cfg_q         <= CFG_DEFAULT;
            lv_flag       <= 1'b0;
            stop2_inhibit <= 1'b0;
        end else begin
            state    <= nxt;
            chip_rst <= (nxt != ST_RUN);
            if (por_evt || lv_evt || (|ext_rst))
                status <= {ext_rst, por_evt | lv_evt, por_evt};
            if (por_s)       cfg_q <= CFG_DEFAULT;
            else if (cfg_we) cfg_q <= cfg_wr;
            if (por_s)         lv_flag <= 1'b0;
            else if (flag_set) lv_flag <= 1'b1;
            else if (flag_ack) lv_flag <= 1'b0;
            stop2_inhibit <= cfg_q.det_en && cfg_q.stop_en;
        end
    end

    assign lv_irq = lv_flag && cfg_q.irq_en;
endmodule

// File: rtl/lvr_supervisor.sv
module lvr_supervisor
    import lvr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYC    = 4,
    parameter int N_EXT       = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             por_below_i,
    input  logic             below_hi_i,
    input  logic             below_lo_i,
    input  logic             in_stop_i,
    input  logic             cfg_we_i,
    input  logic [4:0]       cfg_wr_i,
    input  logic             flag_ack_i,
    input  logic [N_EXT-1:0] ext_rst_i,
    output logic             chip_rst_o,
    output logic             lv_flag_o,
    output logic             lv_irq_o,
    output logic             stop2_inhibit_o,
    output logic [N_EXT+1:0] rst_status_o,
    output logic [4:0]       cfg_o
);
    localparam int N_CMP = 3;

    logic [N_CMP-1:0] raw, cond;
    logic             por_s;
    lvr_cfg_t         cfg_q;

    assign raw = {below_lo_i, below_hi_i, por_below_i};

    // channel 0 is power-on: synchronized only; trip levels are also filtered
    generate
        for (genvar ch = 0; ch < N_CMP; ch++) begin : g_cmp
            lvr_cmp_cond #(
                .STAGES  (SYNC_STAGES),
                .FILT_CYC(FILT_CYC),
                .USE_FILT(ch != 0),
                .RST_VAL (1'b1)
            ) u_cond (
                .clk   (clk),
                .rst   (rst),
                .raw_i (raw[ch]),
                .cond_o(cond[ch])
            );
        end
    endgenerate

    assign por_s = cond[0];

    lvr_ctrl #(.N_EXT(N_EXT)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .por_s        (por_s),
        .hi_f         (cond[1]),
        .lo_f         (cond[2]),
        .in_stop      (in_stop_i),
        .cfg_we       (cfg_we_i),
        .cfg_wr       (lvr_cfg_t'(cfg_wr_i)),
        .flag_ack     (flag_ack_i),
        .ext_rst      (ext_rst_i),
        .chip_rst     (chip_rst_o),
        .lv_flag      (lv_flag_o),
        .lv_irq       (lv_irq_o),
        .stop2_inhibit(stop2_inhibit_o),
        .status       (rst_status_o),
        .cfg_q        (cfg_q)
    );

    assign cfg_o = cfg_q;
endmodule

// File: rtl/lvr_supervisor_chk.sv
module lvr_supervisor_chk
    import lvr_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       por_s,
    input logic       chip_rst_o,
    input logic       lv_flag_o,
    input logic       stop2_inhibit_o,
    input logic [1:0] status_lo,
    input lvr_cfg_t   cfg_q
);
    // R4
    por_hold_chk: assert property (@(posedge clk) disable iff (rst)
        por_s |=> chip_rst_o);

    // R5
    por_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(chip_rst_o) |-> $past(!por_s));

    // R6
    por_status_chk: assert property (@(posedge clk) disable iff (rst)
        (por_s && !chip_rst_o) |=> (status_lo == 2'b11));

    // R9
    flag_mode_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lv_flag_o) |-> ($past(!cfg_q.rst_en) && !chip_rst_o));

    // R3
    stop2_inhibit_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.det_en && cfg_q.stop_en) |=> stop2_inhibit_o);

    // R12
    cfg_default_chk: assert property (@(posedge clk) disable iff (rst)
        por_s |=> (cfg_q == CFG_DEFAULT));
endmodule

bind lvr_supervisor lvr_supervisor_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .por_s          (por_s),
    .chip_rst_o     (chip_rst_o),
    .lv_flag_o      (lv_flag_o),
    .stop2_inhibit_o(stop2_inhibit_o),
    .status_lo      (rst_status_o[1:0]),
    .cfg_q          (cfg_q)
);

// File: tb/lvr_supervisor_test.sv
module lvr_supervisor_test;
    localparam int N_EXT = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic             por_below_i = 1'b1, below_hi_i = 1'b1, below_lo_i = 1'b1;
    logic             in_stop_i = 1'b0, cfg_we_i = 1'b0, flag_ack_i = 1'b0;
    logic [4:0]       cfg_wr_i = '0;
    logic [N_EXT-1:0] ext_rst_i = '0;
    logic             chip_rst_o, lv_flag_o, lv_irq_o, stop2_inhibit_o;
    logic [N_EXT+1:0] rst_status_o;
    logic [4:0]       cfg_o;

    lvr_supervisor #(.SYNC_STAGES(2), .FILT_CYC(4), .N_EXT(N_EXT)) uut (
        .clk(clk), .rst(rst), .por_below_i(por_below_i), .below_hi_i(below_hi_i),
        .below_lo_i(below_lo_i), .in_stop_i(in_stop_i), .cfg_we_i(cfg_we_i),
        .cfg_wr_i(cfg_wr_i), .flag_ack_i(flag_ack_i), .ext_rst_i(ext_rst_i),
        .chip_rst_o(chip_rst_o), .lv_flag_o(lv_flag_o), .lv_irq_o(lv_irq_o),
        .stop2_inhibit_o(stop2_inhibit_o), .rst_status_o(rst_status_o), .cfg_o(cfg_o)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wcfg(input logic [4:0] v);
        @(negedge clk);
        cfg_we_i = 1'b1;
        cfg_wr_i = v;
        @(negedge clk);
        cfg_we_i = 1'b0;
        idle(3);
    endtask

    task automatic set_supply(input logic hi, input logic lo);
        below_hi_i = hi;
        below_lo_i = lo;
    endtask

    task automatic t_reset_state();
        chk("R12 cfg after rst", cfg_o, 5'b00011);
        chk("R6 status after rst", rst_status_o, 5'b00011);
        chk("R4 chip_rst after rst", chip_rst_o, 1);
        chk("R9 flag after rst", lv_flag_o, 0);
        chk("R3 inhibit after rst", stop2_inhibit_o, 0);
    endtask

    task automatic t_por_release();
        por_below_i = 1'b0;
        idle(15);
        chk("R5 held while below low level", chip_rst_o, 1);
        set_supply(1'b1, 1'b0);
        idle(15);
        chk("R5 released above low level, high level ignored", chip_rst_o, 0);
        chk("R6 status kept after release", rst_status_o, 5'b00011);
        set_supply(1'b0, 1'b0);
        idle(10);
    endtask

    task automatic t_glitch();
        set_supply(1'b1, 1'b1);
        idle(2);
        set_supply(1'b0, 1'b0);
        idle(15);
        chk("R1 short glitch ignored", chip_rst_o, 0);
        chk("R1 status untouched by glitch", rst_status_o, 5'b00011);
    endtask

    task automatic t_lvd_reset();
        wcfg(5'b00111);
        chk("R12 cfg readback", cfg_o, 5'b00111);
        below_hi_i = 1'b1;
        idle(15);
        chk("R7 high-level trip resets", chip_rst_o, 1);
        chk("R8 status low-voltage only", rst_status_o, 5'b00010);
        idle(20);
        chk("R7 reset held while tripped", chip_rst_o, 1);
        below_hi_i = 1'b0;
        idle(15);
        chk("R7 reset released", chip_rst_o, 0);
    endtask

    task automatic t_stop();
        wcfg(5'b00011);
        chk("R3 inhibit off without keep-alive", stop2_inhibit_o, 0);
        in_stop_i = 1'b1;
        set_supply(1'b1, 1'b1);
        idle(15);
        chk("R2 detector off in stop", chip_rst_o, 0);
        set_supply(1'b0, 1'b0);
        idle(10);
        wcfg(5'b01011);
        chk("R3 inhibit on", stop2_inhibit_o, 1);
        set_supply(1'b1, 1'b1);
        idle(15);
        chk("R2 detector alive in stop with keep-alive", chip_rst_o, 1);
        set_supply(1'b0, 1'b0);
        idle(15);
        chk("R7 release after stop trip", chip_rst_o, 0);
        in_stop_i = 1'b0;
        idle(2);
    endtask

    task automatic t_det_off();
        wcfg(5'b00010);
        set_supply(1'b1, 1'b1);
        idle(15);
        chk("R2 disabled detector no reset", chip_rst_o, 0);
        chk("R2 disabled detector no flag", lv_flag_o, 0);
        set_supply(1'b0, 1'b0);
        idle(10);
    endtask

    task automatic t_flag();
        wcfg(5'b10001);
        set_supply(1'b1, 1'b1);
        idle(15);
        chk("R9 no reset in flag mode", chip_rst_o, 0);
        chk("R9 flag set", lv_flag_o, 1);
        chk("R9 irq with enable", lv_irq_o, 1);
        set_supply(1'b0, 1'b0);
        idle(10);
        chk("R10 flag sticky", lv_flag_o, 1);
        flag_ack_i = 1'b1;
        idle(1);
        flag_ack_i = 1'b0;
        idle(2);
        chk("R10 flag cleared by ack", lv_flag_o, 0);
        chk("R10 irq cleared by ack", lv_irq_o, 0);
        wcfg(5'b00001);
        set_supply(1'b1, 1'b1);
        idle(15);
        chk("R9 flag set, irq disabled", lv_flag_o, 1);
        chk("R9 irq masked", lv_irq_o, 0);
        set_supply(1'b0, 1'b0);
        idle(10);
        flag_ack_i = 1'b1;
        idle(1);
        flag_ack_i = 1'b0;
        idle(2);
        chk("R10 second ack", lv_flag_o, 0);
    endtask

    task automatic t_ext();
        ext_rst_i = 3'b010;
        idle(1);
        ext_rst_i = '0;
        idle(2);
        chk("R11 status from external source", rst_status_o, 5'b01000);
        chk("R11 no chip reset from external", chip_rst_o, 0);
    endtask

    task automatic t_por_run();
        wcfg(5'b01011);
        por_below_i = 1'b1;
        set_supply(1'b1, 1'b1);
        idle(4);
        chk("R4 power-on asserts reset", chip_rst_o, 1);
        idle(6);
        chk("R6 status on power-on", rst_status_o, 5'b00011);
        chk("R12 cfg defaults on power-on", cfg_o, 5'b00011);
        chk("R3 inhibit dropped", stop2_inhibit_o, 0);
        por_below_i = 1'b0;
        set_supply(1'b0, 1'b0);
        idle(15);
        chk("R5 release after second power-on", chip_rst_o, 0);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        t_reset_state();
        t_por_release();
        t_glitch();
        t_lvd_reset();
        t_stop();
        t_det_off();
        t_flag();
        t_ext();
        t_por_run();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule